// File: doc/BRIEF.md
# Instruction cycle pairing accumulator

This block sits behind an instruction retirement stage and works out how many bus cycles each retired instruction really costs on a memory bus whose accesses fall into 4-cycle slots. Each record carries a raw cycle count, a family index and an extra bus penalty (non-zero when the instruction used an indexed addressing form that misaligns a bus access). An instruction that does not pair has its count plus penalty rounded up to a slot boundary. Two back-to-back instructions that land on opposite halves of a slot may pair, so that the second one gives back part of the rounding its predecessor paid.

Which family pairs are allowed is held in a square bit table written through a small write port. The block remembers the family and the unrounded effective count of the last accepted record, produces the charged cycle count and a paired flag one clock after each accepted record, and adds the charged count, scaled down by a frequency shift, to a wrapping main counter and a wider global counter.

Records enter on a valid/ready stream and results leave on a valid/ready stream. A record is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while a table write is presented and while an undelivered result is held with `out_ready` low; a held result stays unchanged until it is taken. Records wait at the source under back-pressure; none is dropped.

Top module: `cyc_pair_acc`

## Requirements
- R1: A record that does not pair is charged (raw + penalty) rounded up to the next multiple of 4, and its paired flag is 0.
- R2: A record pairs only when the table bit at [previous family][current family] is 1, the previous effective count modulo 4 equals 2, and either the current raw count modulo 4 equals 2 or the current penalty is non-zero.
- R3: A paired record whose raw count modulo 4 equals 2 is charged raw - 2, with no penalty added and no rounding, and its paired flag is 1.
- R4: A paired record whose raw count modulo 4 is not 2 (pairing granted through a non-zero penalty) is charged its raw count unchanged, with its paired flag 1.
- R5: Every accepted record replaces the previous family with its own family and the previous effective count with raw + penalty, unrounded.
- R6: On each accepted record both counters add the charged count shifted right by `cfg_shift`; the main counter wraps at 2^MAIN_W and the global counter at 2^GLOB_W; without an accepted record neither changes.
- R7: Synchronous reset clears the previous family and effective count, both counters, every table bit and `out_valid`, so the first record after reset cannot pair.
- R8: With `tbl_we` high, the table bit at [`tbl_prev_fam`][`tbl_cur_fam`] takes `tbl_bit` on the clock edge, and `in_ready` is 0 for that cycle.
- R9: A record accepted on an edge gives `out_valid` high after that edge with its result; `in_ready` equals not `tbl_we` and (not `out_valid` or `out_ready`); a result held with `out_ready` low keeps its value.
- R10: A record's penalty affects only its own charge and the stored effective count; the next record is charged from its own penalty alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_shift | input | SHIFT_W | Right shift applied to the charged count before counting |
| tbl_we | input | 1 | Table write strobe |
| tbl_prev_fam | input | FAM_W | Table row: preceding family |
| tbl_cur_fam | input | FAM_W | Table column: following family |
| tbl_bit | input | 1 | Permission bit to write |
| in_valid | input | 1 | Record present |
| in_ready | output | 1 | Record can be taken |
| in_raw_cyc | input | CYC_W | Raw cycle count |
| in_family | input | FAM_W | Family index |
| in_penalty | input | PEN_W | Bus penalty cycles |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken by sink |
| out_charged | output | CYC_W+2 | Charged cycles (before the shift) |
| out_paired | output | 1 | Record paired with its predecessor |
| main_cycles | output | MAIN_W | Wrapping main cycle counter |
| global_cycles | output | GLOB_W | Global cycle counter |

## Verification
The bench builds the block with 8 families, 7-bit raw counts, 3-bit penalties and a 10-bit main counter, so every table cell is written and read many times and the main counter wraps within a few hundred records. Random penalties up to 7 reach pairing through odd raw counts as well as the multiple-of-4 case, and random stalls on `out_ready` together with table writes presented beside a pending record reach every back-pressure path. All four shift values are used while the counters run.

// File: rtl/cpa_pkg.sv
package cpa_pkg;
  // Phase of a cycle count that sits half way into a 4-cycle slot
  localparam logic [1:0] PHASE_HALF = 2'b10;

  typedef enum logic [1:0] {
    CK_ROUND     = 2'd0,
    CK_PAIR_TRIM = 2'd1,
    CK_PAIR_KEEP = 2'd2
  } charge_kind_e;
endpackage

// File: rtl/cpa_perm_table.sv
module cpa_perm_table #(
  parameter int FAM_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [FAM_W-1:0] wr_row,
  input  logic [FAM_W-1:0] wr_col,
  input  logic             wr_bit,
  input  logic [FAM_W-1:0] rd_row,
  input  logic [FAM_W-1:0] rd_col,
  output logic             rd_bit
);
  localparam int NFAM = 1 << FAM_W;

  logic [NFAM-1:0] rows [NFAM];

  for (genvar r = 0; r < NFAM; r++) begin : g_row
    logic row_we;
    assign row_we = we && (wr_row == FAM_W'(r));
    always_ff @(posedge clk) begin
      if (rst) begin
        rows[r] <= '0;
      end else if (row_we) begin
        rows[r][wr_col] <= wr_bit;
      end
    end
  end

  assign rd_bit = rows[rd_row][rd_col];

  // R8
  tbl_store_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> rows[$past(wr_row)][$past(wr_col)] == $past(wr_bit));
endmodule

// File: rtl/cpa_charge_calc.sv
module cpa_charge_calc import cpa_pkg::*; #(
  parameter int CYC_W = 8,
  parameter int PEN_W = 3,
  localparam int EFF_W = ((CYC_W > PEN_W) ? CYC_W : PEN_W) + 1,
  localparam int CHG_W = EFF_W + 1
) (
  input  logic [CYC_W-1:0] raw,
  input  logic [PEN_W-1:0] pen,
  input  logic [EFF_W-1:0] prev_eff,
  input  logic             perm_ok,
  output logic             pair,
  output charge_kind_e     kind,
  output logic [EFF_W-1:0] eff,
  output logic [CHG_W-1:0] charged
);
  logic             prev_half;
  logic             raw_half;
  logic             pen_nz;
  logic [CHG_W-1:0] rounded;

  assign eff       = EFF_W'(raw) + EFF_W'(pen);
  assign rounded   = (CHG_W'(eff) + CHG_W'(3)) & ~CHG_W'(3);
  assign prev_half = (prev_eff[1:0] == PHASE_HALF);
  assign raw_half  = (raw[1:0] == PHASE_HALF);
  assign pen_nz    = |pen;
  assign pair      = perm_ok && prev_half && (raw_half || pen_nz);

  always_comb begin
    if (!pair)         kind = CK_ROUND;
    else if (raw_half) kind = CK_PAIR_TRIM;
    else               kind = CK_PAIR_KEEP;
  end

  always_comb begin
    case (kind)
      CK_PAIR_TRIM: charged = CHG_W'(raw) - CHG_W'(2);
      CK_PAIR_KEEP: charged = CHG_W'(raw);
      default:      charged = rounded;
    endcase
  end
endmodule

// File: rtl/cpa_counters.sv
module cpa_counters #(
  parameter int CHG_W   = 10,
  parameter int SHIFT_W = 2,
  parameter int MAIN_W  = 32,
  parameter int GLOB_W  = 48
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               add_en,
  input  logic [CHG_W-1:0]   charge,
  input  logic [SHIFT_W-1:0] shift,
  output logic [MAIN_W-1:0]  main_cnt,
  output logic [GLOB_W-1:0]  glob_cnt
);
  logic [CHG_W-1:0] scaled;
  assign scaled = charge >> shift;

  always_ff @(posedge clk) begin
    if (rst) begin
      main_cnt <= '0;
      glob_cnt <= '0;
    end else if (add_en) begin
      main_cnt <= main_cnt + MAIN_W'(scaled);
      glob_cnt <= glob_cnt + GLOB_W'(scaled);
    end
  end

  // R6
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !add_en |=> $stable(main_cnt) && $stable(glob_cnt));
endmodule

// File: rtl/cyc_pair_acc.sv
module cyc_pair_acc import cpa_pkg::*; #(
  parameter int FAM_W   = 5,
  parameter int CYC_W   = 8,
  parameter int PEN_W   = 3,
  parameter int SHIFT_W = 2,
  parameter int MAIN_W  = 32,
  parameter int GLOB_W  = 48,
  localparam int EFF_W  = ((CYC_W > PEN_W) ? CYC_W : PEN_W) + 1,
  localparam int CHG_W  = EFF_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic               tbl_we,
  input  logic [FAM_W-1:0]   tbl_prev_fam,
  input  logic [FAM_W-1:0]   tbl_cur_fam,
  input  logic               tbl_bit,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [CYC_W-1:0]   in_raw_cyc,
  input  logic [FAM_W-1:0]   in_family,
  input  logic [PEN_W-1:0]   in_penalty,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [CHG_W-1:0]   out_charged,
  output logic               out_paired,
  output logic [MAIN_W-1:0]  main_cycles,
  output logic [GLOB_W-1:0]  global_cycles
);
  logic [FAM_W-1:0] prev_fam_q;
  logic [EFF_W-1:0] prev_eff_q;
  logic             perm_ok;
  logic             pair;
  charge_kind_e     kind;
  logic [EFF_W-1:0] eff;
  logic [CHG_W-1:0] charged;
  logic             accept;

  assign in_ready = !tbl_we && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;

  cpa_perm_table #(.FAM_W(FAM_W)) u_table (
    .clk    (clk),
    .rst    (rst),
    .we     (tbl_we),
    .wr_row (tbl_prev_fam),
    .wr_col (tbl_cur_fam),
    .wr_bit (tbl_bit),
    .rd_row (prev_fam_q),
    .rd_col (in_family),
    .rd_bit (perm_ok)
  );

  cpa_charge_calc #(.CYC_W(CYC_W), .PEN_W(PEN_W)) u_calc (
    .raw      (in_raw_cyc),
    .pen      (in_penalty),
    .prev_eff (prev_eff_q),
    .perm_ok  (perm_ok),
    .pair     (pair),
    .kind     (kind),
    .eff      (eff),
    .charged  (charged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_fam_q  <= '0;
      prev_eff_q  <= '0;
      out_valid   <= 1'b0;
      out_charged <= '0;
      out_paired  <= 1'b0;
    end else begin
      if (accept) begin
        prev_fam_q  <= in_family;
        prev_eff_q  <= eff;
        out_charged <= charged;
        out_paired  <= (kind != CK_ROUND);
        out_valid   <= 1'b1;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end

  cpa_counters #(
    .CHG_W   (CHG_W),
    .SHIFT_W (SHIFT_W),
    .MAIN_W  (MAIN_W),
    .GLOB_W  (GLOB_W)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .add_en   (accept),
    .charge   (charged),
    .shift    (cfg_shift),
    .main_cnt (main_cycles),
    .glob_cnt (global_cycles)
  );

  // R1
  unpaired_round_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_paired |-> out_charged[1:0] == 2'b00);

  // R9
  accept_result_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_charged) && $stable(out_paired));

  // R5
  stream_gap_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(prev_fam_q) && $stable(prev_eff_q));
endmodule

// File: tb/tb_cyc_pair_acc.sv
module tb_cyc_pair_acc;
  localparam int FAM_W = 3, CYC_W = 7, PEN_W = 3, SHIFT_W = 2, MAIN_W = 10, GLOB_W = 24;
  localparam int CHG_W = CYC_W + 2;
  localparam int NF = 1 << FAM_W;

  logic clk = 0, rst = 1;
  logic [SHIFT_W-1:0] cfg_shift = '0;
  logic tbl_we = 0, tbl_bit = 0;
  logic [FAM_W-1:0] tbl_prev_fam = '0, tbl_cur_fam = '0;
  logic in_valid = 0, in_ready;
  logic [CYC_W-1:0] in_raw_cyc = '0;
  logic [FAM_W-1:0] in_family = '0;
  logic [PEN_W-1:0] in_penalty = '0;
  logic out_valid, out_ready = 1, out_paired;
  logic [CHG_W-1:0] out_charged;
  logic [MAIN_W-1:0] main_cycles;
  logic [GLOB_W-1:0] global_cycles;

  always #10 clk = ~clk; // 50 MHz

  cyc_pair_acc #(.FAM_W(FAM_W), .CYC_W(CYC_W), .PEN_W(PEN_W), .SHIFT_W(SHIFT_W),
                 .MAIN_W(MAIN_W), .GLOB_W(GLOB_W)) dut (
    .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .tbl_we(tbl_we),
    .tbl_prev_fam(tbl_prev_fam), .tbl_cur_fam(tbl_cur_fam), .tbl_bit(tbl_bit),
    .in_valid(in_valid), .in_ready(in_ready), .in_raw_cyc(in_raw_cyc),
    .in_family(in_family), .in_penalty(in_penalty), .out_valid(out_valid),
    .out_ready(out_ready), .out_charged(out_charged), .out_paired(out_paired),
    .main_cycles(main_cycles), .global_cycles(global_cycles));

  int checks = 0, fails = 0;
  bit mon_on = 0, stall_mode = 0, done = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit perm [NF][NF];
  int m_pf, m_peff, m_ch;
  bit m_ov, m_pd;
  longint m_main, m_glob;
  string m_tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      foreach (perm[a, b]) perm[a][b] = 0;
      m_pf = 0; m_peff = 0; m_main = 0; m_glob = 0; m_ov = 0; m_pd = 0; m_ch = 0;
    end else begin
      bit rdy, take;
      rdy  = !tbl_we && (!m_ov || out_ready);
      take = in_valid && rdy;
      if (tbl_we) perm[tbl_prev_fam][tbl_cur_fam] = tbl_bit;
      if (take) begin
        int raw, pen, f;
        bit pr;
        raw = int'(in_raw_cyc); pen = int'(in_penalty); f = int'(in_family);
        pr = perm[m_pf][f] && (m_peff % 4 == 2) && ((raw % 4 == 2) || pen != 0);
        if (pr && raw % 4 == 2) begin m_ch = raw - 2; m_tag = "R3"; end
        else if (pr)            begin m_ch = raw;     m_tag = "R4"; end
        else begin m_ch = ((raw + pen + 3) / 4) * 4;  m_tag = "R1"; end
        m_pd = pr;
        m_peff = raw + pen; m_pf = f;
        m_main = (m_main + (m_ch >> cfg_shift)) % (longint'(1) << MAIN_W);
        m_glob = (m_glob + (m_ch >> cfg_shift)) % (longint'(1) << GLOB_W);
        m_ov = 1;
      end else if (out_ready) m_ov = 0;
    end
  end

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (mon_on && !rst) begin
      bit erdy;
      erdy = !tbl_we && (!m_ov || out_ready);
      chk(in_ready == erdy, tbl_we ? "R8 in_ready" : "R9 in_ready", in_ready, erdy);
      chk(out_valid == m_ov, "R9 out_valid", out_valid, m_ov);
      if (m_ov) begin
        chk(int'(out_charged) == m_ch, m_tag, out_charged, m_ch);
        chk(out_paired == m_pd, "R2 paired", out_paired, m_pd);
      end
      chk(longint'(main_cycles) == m_main, "R6 main", main_cycles, m_main);
      chk(longint'(global_cycles) == m_glob, "R6 global", global_cycles, m_glob);
    end
  end

  always @(negedge clk) if (stall_mode) out_ready = ($urandom_range(0, 3) != 0);

  task automatic send(int raw, int fam, int pen);
    @(negedge clk);
    in_valid = 1; in_raw_cyc = CYC_W'(raw); in_family = FAM_W'(fam); in_penalty = PEN_W'(pen);
    forever begin
      #2;
      if (in_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
  endtask

  task automatic send_chk(int raw, int fam, int pen, int ech, bit epd, string tag);
    send(raw, fam, pen);
    @(negedge clk); in_valid = 0; #2;
    chk(int'(out_charged) == ech, tag, out_charged, ech);
    chk(out_paired == epd, {tag, " flag"}, out_paired, epd);
  endtask

  task automatic wr_tbl(int a, int b, bit v);
    @(negedge clk);
    in_valid = 0; tbl_we = 1; tbl_prev_fam = FAM_W'(a); tbl_cur_fam = FAM_W'(b); tbl_bit = v;
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 20);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R7: reset state
    chk(out_valid == 0, "R7 out_valid", out_valid, 0);
    chk(main_cycles == 0, "R7 main", main_cycles, 0);
    chk(global_cycles == 0, "R7 global", global_cycles, 0);
    @(negedge clk); rst = 0; mon_on = 1;

    // R8: table loads
    wr_tbl(0, 1, 1); wr_tbl(1, 2, 1); wr_tbl(2, 2, 1); wr_tbl(2, 5, 1); wr_tbl(3, 3, 1);
    // R7: first record after reset cannot pair even with a permitted entry
    send_chk(14, 1, 0, 16, 0, "R7 first");
    // R3: 14 then 14 in a permitted pair
    send_chk(14, 2, 0, 12, 1, "R3");
    // R4: penalty 4 on a multiple of 4 pairs, charged unchanged
    send_chk(20, 2, 4, 20, 1, "R4");
    // R5: stored effective count is 24, so no pairing next
    send_chk(14, 2, 0, 16, 0, "R5");
    send_chk(14, 5, 0, 12, 1, "R3 second");
    // R1: table bit [5][5] clear, penalty added then rounded
    send_chk(14, 5, 2, 16, 0, "R1");
    // R10: penalty not carried into the next record
    send_chk(13, 3, 0, 16, 0, "R10");
    // R2: raw odd with penalty after an effective 2 mod 4 count pairs (keep raw)
    send_chk(10, 3, 0, 12, 0, "R2 setup");
    send_chk(9, 3, 3, 9, 1, "R2");
    // R2: table bit cleared again blocks pairing
    wr_tbl(2, 2, 0);
    send_chk(14, 2, 0, 16, 0, "R2 prep");
    send_chk(14, 2, 0, 16, 0, "R2 blocked");

    // R8: table write beside a pending record holds it back
    @(negedge clk);
    in_valid = 1; in_raw_cyc = 7'd6; in_family = 3'd4; in_penalty = '0;
    tbl_we = 1; tbl_prev_fam = 3'd2; tbl_cur_fam = 3'd4; tbl_bit = 1;
    #2; chk(in_ready == 0, "R8 stall", in_ready, 0);
    @(negedge clk); tbl_we = 0; // record taken on the next edge, pairs via new bit
    @(negedge clk); in_valid = 0; #2;
    chk(int'(out_charged) == 4 && out_paired, "R8 new bit", out_charged, 4);

    // R6/R9: random traffic with stalls, shifts and table churn
    stall_mode = 1;
    for (int i = 0; i < 600; i++) begin
      if (i % 40 == 0) cfg_shift = SHIFT_W'($urandom_range(0, 3));
      if (i % 25 == 0) begin
        stall_mode = 0; out_ready = 1;
        for (int k = 0; k < 6; k++)
          wr_tbl($urandom_range(0, NF - 1), $urandom_range(0, NF - 1), $urandom_range(0, 3) != 0);
        stall_mode = 1;
      end
      send($urandom_range(0, 127) & ~($urandom_range(0, 1) ? 0 : 1),
           $urandom_range(0, NF - 1),
           ($urandom_range(0, 2) == 0) ? $urandom_range(0, 7) : 0);
    end
    @(negedge clk); in_valid = 0;
    stall_mode = 0; out_ready = 1;
    repeat (4) @(negedge clk);
    #3;
    finish_run();
  end
endmodule